// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the value of a free-running 64-bit time counter at the moment a packet of interest starts on the transmit path or the receive path. It keeps that value until software collects it. Each direction holds exactly one stamp. While a stamp is held, later packets in that direction are not stamped, so software always knows which packet the held value belongs to. Software reads the low word of the stamp and then the high word. Reading the high word frees the direction for the next capture.

Upstream parsing is reduced to a per-packet descriptor that is valid on a start-of-packet strobe. The descriptor carries the ethertype, IP protocol, UDP source and destination ports, precision-time-protocol version and message type. A receive classifier uses this descriptor to decide whether the packet is stamped. It can stamp every packet, UDP-carried version-1 packets of one message type, layer-2 or UDP version-2 packets of one message type, or every version-2 event message. On the transmit side every strobe is stamped while capture is enabled. A single level interrupt reports a held transmit stamp.

Top module: `ptp_stamp_capture`

## Requirements
- R1: After reset, every register reads 0: both enables, both valid bits, the interrupt mask, the mode, the message selector and all four capture words. The irq output is 0.
- R2: Register map, 32-bit words. Address 0 is the transmit control register: bit0 enable (rw), bit1 valid (ro), bit2 interrupt mask (rw). Address 1 is the receive control register: bit0 enable (rw), bit1 valid (ro), bits6:4 mode (rw), bit7 source-port check (rw). Address 2 holds the message-type selector in bits3:0. Address 3 is the transmit stamp low word and address 4 the transmit stamp high word. Address 5 is the receive stamp low word and address 6 the receive stamp high word.
- R3: When tx_sop is high while transmit enable is 1 and transmit valid is 0, the stamp registers take sys_time from that cycle and transmit valid reads 1 from the next cycle.
- R4: While a direction's valid bit is 1, further start strobes in that direction change neither its stamp nor its valid bit.
- R5: A read of the high stamp word (address 4 or 6) clears that direction's valid bit. A read of the low word leaves it set.
- R6: With a direction's enable at 0, no capture takes place in that direction.
- R7: Receive mode 1 stamps every receive packet.
- R8: Receive mode 2 stamps a packet only when all of these hold: IP protocol 17, UDP destination port 319, version 1, and message type equal to the selector.
- R9: Receive mode 3 stamps a packet only when it is version 2, its message type equals the selector, and it either has ethertype 0x88F7 or meets the UDP condition of R8.
- R10: Receive mode 4 stamps a packet only when it is version 2 with message type 0 to 3 and either has ethertype 0x88F7 or meets the UDP condition.
- R11: When the source-port check bit is 1, the UDP condition also requires UDP source port 319.
- R12: Receive mode 0 and mode codes 5 to 7 stamp nothing.
- R13: irq is 1 exactly while transmit valid is 1 and the transmit interrupt mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Running time counter value |
| tx_sop | input | 1 | Start strobe of a transmit packet to be stamped |
| rx_sop | input | 1 | Start strobe of a receive packet; the descriptor is valid with it |
| rx_ethertype | input | 16 | Receive packet ethertype |
| rx_ip_proto | input | 8 | Receive packet IP protocol number |
| rx_udp_src | input | 16 | Receive UDP source port |
| rx_udp_dst | input | 16 | Receive UDP destination port |
| rx_ptp_ver | input | 4 | Protocol version carried in the packet |
| rx_msg_type | input | 4 | Protocol message type carried in the packet |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on high stamp words) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Transmit stamp interrupt level |

## Verification
The receive classifier runs on random descriptors. These are biased toward the protocol ethertype, protocol 17, port 319, versions 1 and 2 and low message types, so that near-miss packets appear often. A near miss differs from a match in exactly one field, which separates the version check, the message-type comparison, the ethertype path, the UDP path and the source-port check. Random mode codes include 0 and the undefined codes, which separates "stamp nothing" from "stamp everything". Directed sequences cover lockout and re-arming. They send a second strobe while a stamp is held, read the low word alone and then the high word, and strobe with the enable off. The interrupt is checked with its mask set and with its mask cleared.

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture #(
  parameter int REG_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [15:0] PTP_ETYPE = 16'h88F7,
  parameter logic [15:0] PTP_PORT = 16'd319,
  parameter logic [7:0] UDP_PROTO = 8'd17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*REG_W-1:0] sys_time,
  input  logic              tx_sop,
  input  logic              rx_sop,
  input  logic [15:0]       rx_ethertype,
  input  logic [7:0]        rx_ip_proto,
  input  logic [15:0]       rx_udp_src,
  input  logic [15:0]       rx_udp_dst,
  input  logic [3:0]        rx_ptp_ver,
  input  logic [3:0]        rx_msg_type,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int TIME_W = 2*REG_W;
  localparam logic [ADDR_W-1:0] A_TXCTL = 0, A_RXCTL = 1, A_MSG = 2,
    A_TXLO = 3, A_TXHI = 4, A_RXLO = 5, A_RXHI = 6;
  localparam logic [2:0] M_ALL = 3'd1, M_V1 = 3'd2, M_V2 = 3'd3, M_V2EV = 3'd4;

  logic tx_en, tx_mask, tx_valid, rx_en, rx_valid, rx_srcchk;
  logic [2:0] rx_mode;
  logic [3:0] msg_sel;
  logic [TIME_W-1:0] tx_stamp, rx_stamp;

  wire tx_hi_rd = reg_rd && reg_addr == A_TXHI;
  wire rx_hi_rd = reg_rd && reg_addr == A_RXHI;

  wire l2_hit = rx_ethertype == PTP_ETYPE;
  wire l4_hit = rx_ip_proto == UDP_PROTO && rx_udp_dst == PTP_PORT &&
                (!rx_srcchk || rx_udp_src == PTP_PORT);
  wire ver1 = rx_ptp_ver == 4'd1;
  wire ver2 = rx_ptp_ver == 4'd2;
  wire type_hit = rx_msg_type == msg_sel;
  wire event_hit = rx_msg_type < 4'd4;

  logic rx_hit;
  always_comb begin
    case (rx_mode)
      M_ALL:   rx_hit = 1'b1;
      M_V1:    rx_hit = l4_hit && ver1 && type_hit;
      M_V2:    rx_hit = (l2_hit || l4_hit) && ver2 && type_hit;
      M_V2EV:  rx_hit = (l2_hit || l4_hit) && ver2 && event_hit;
      default: rx_hit = 1'b0;
    endcase
  end

  wire tx_take = tx_en && tx_sop && !tx_valid;
  wire rx_take = rx_en && rx_sop && !rx_valid && rx_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= 1'b0; tx_mask <= 1'b0; tx_valid <= 1'b0;
      rx_en <= 1'b0; rx_valid <= 1'b0; rx_srcchk <= 1'b0;
      rx_mode <= '0; msg_sel <= '0;
      tx_stamp <= '0; rx_stamp <= '0;
    end else begin
      if (reg_wr && reg_addr == A_TXCTL) begin
        tx_en <= reg_wdata[0];
        tx_mask <= reg_wdata[2];
      end
      if (reg_wr && reg_addr == A_RXCTL) begin
        rx_en <= reg_wdata[0];
        rx_mode <= reg_wdata[6:4];
        rx_srcchk <= reg_wdata[7];
      end
      if (reg_wr && reg_addr == A_MSG) msg_sel <= reg_wdata[3:0];

      if (tx_take) begin
        tx_stamp <= sys_time;
        tx_valid <= 1'b1;
      end else if (tx_hi_rd) tx_valid <= 1'b0;

      if (rx_take) begin
        rx_stamp <= sys_time;
        rx_valid <= 1'b1;
      end else if (rx_hi_rd) rx_valid <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXCTL: reg_rdata[2:0] = {tx_mask, tx_valid, tx_en};
      A_RXCTL: reg_rdata[7:0] = {rx_srcchk, rx_mode, 2'b00, rx_valid, rx_en};
      A_MSG:   reg_rdata[3:0] = msg_sel;
      A_TXLO:  reg_rdata = tx_stamp[REG_W-1:0];
      A_TXHI:  reg_rdata = tx_stamp[TIME_W-1:REG_W];
      A_RXLO:  reg_rdata = rx_stamp[REG_W-1:0];
      A_RXHI:  reg_rdata = rx_stamp[TIME_W-1:REG_W];
      default: reg_rdata = '0;
    endcase
  end

  assign irq = tx_valid && tx_mask;

  // Held stamps stay put until the high word is read.
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_stamp)));
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_hi_rd) |=> (rx_valid && $stable(rx_stamp)));
  assert_tx_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_hi_rd) |=> !tx_valid);
  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_valid) |=> !rx_valid);
  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_valid) |=> !tx_valid);
  assert_irq_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> !irq);
  assert_tx_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_sop && !tx_valid) |=> (tx_valid && tx_stamp == $past(sys_time)));
endmodule

// File: tb/test_ptp_stamp_capture.sv
module test_ptp_stamp_capture;
  logic clk = 0, rst_n = 0;
  logic [63:0] sys_time = 0;
  logic tx_sop = 0, rx_sop = 0;
  logic [15:0] rx_ethertype = 0, rx_udp_src = 0, rx_udp_dst = 0;
  logic [7:0] rx_ip_proto = 0;
  logic [3:0] rx_ptp_ver = 0, rx_msg_type = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptp_stamp_capture i_ptp_stamp_capture (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic tx_pkt(input logic [63:0] t);
    @(negedge clk); sys_time = t; tx_sop = 1;
    @(posedge clk); #1 tx_sop = 0; sys_time = t + 64'd99;
  endtask

  task automatic rx_pkt(input logic [63:0] t, input logic [15:0] et, input logic [7:0] pr,
                        input logic [15:0] sp, input logic [15:0] dp,
                        input logic [3:0] ver, input logic [3:0] mt);
    @(negedge clk); sys_time = t; rx_sop = 1;
    rx_ethertype = et; rx_ip_proto = pr; rx_udp_src = sp; rx_udp_dst = dp;
    rx_ptp_ver = ver; rx_msg_type = mt;
    @(posedge clk); #1 rx_sop = 0; sys_time = t + 64'd77;
  endtask

  function automatic bit expect_hit(input logic [2:0] mode, input bit srcchk, input logic [3:0] sel,
      input logic [15:0] et, input logic [7:0] pr, input logic [15:0] sp,
      input logic [15:0] dp, input logic [3:0] ver, input logic [3:0] mt);
    bit l2 = (et == 16'h88F7);
    bit l4 = (pr == 8'd17) && (dp == 16'd319) && (!srcchk || sp == 16'd319);
    case (mode)
      3'd1: return 1;
      3'd2: return l4 && ver == 4'd1 && mt == sel;
      3'd3: return (l2 || l4) && ver == 4'd2 && mt == sel;
      3'd4: return (l2 || l4) && ver == 4'd2 && mt < 4'd4;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [63:0] t;
    void'($urandom(32'd1588));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset values
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], d);
      chk("R1 reset reg", {32'd0, d}, 64'd0);
    end
    chk("R1 reset irq", {63'd0, irq}, 64'd0);

    // R6 tx disabled
    tx_pkt(64'h1111);
    rd(3'd0, d); chk("R6 tx disabled no valid", {32'd0, d}, 64'd0);

    // R3 tx capture, R2 layout, R13 irq
    wr(3'd0, 32'h5);
    t = 64'hDEAD_BEEF_0123_4567;
    tx_pkt(t);
    chk("R13 irq with mask", {63'd0, irq}, 64'd1);
    rd(3'd0, d); chk("R3 tx valid set", {32'd0, d}, 64'h7);
    tx_pkt(64'hAAAA_BBBB_CCCC_DDDD);
    rd(3'd3, lo); chk("R4 tx low held", {32'd0, lo}, {32'd0, t[31:0]});
    rd(3'd0, d); chk("R5 low read keeps valid", {32'd0, d}, 64'h7);
    rd(3'd4, hi); chk("R3 tx high", {32'd0, hi}, {32'd0, t[63:32]});
    rd(3'd0, d); chk("R5 high read clears", {32'd0, d}, 64'h5);
    chk("R13 irq drops", {63'd0, irq}, 64'd0);
    wr(3'd0, 32'h1);
    t = 64'h0000_0001_FFFF_FFFF;
    tx_pkt(t);
    chk("R13 irq masked", {63'd0, irq}, 64'd0);
    rd(3'd3, lo); rd(3'd4, hi);
    chk("R5 rearm recapture", {hi, lo}, t);

    // R12 none / undefined modes, R6 rx gate
    wr(3'd1, 32'h01);
    rx_pkt(64'h5, 16'h88F7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
    rd(3'd1, d); chk("R12 mode0 none", {63'd0, d[1]}, 64'd0);
    wr(3'd1, 32'h71);
    rx_pkt(64'h5, 16'h88F7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
    rd(3'd1, d); chk("R12 mode7 none", {63'd0, d[1]}, 64'd0);
    wr(3'd1, 32'h10);
    rx_pkt(64'h5, 16'h88F7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
    rd(3'd1, d); chk("R6 rx disabled", {63'd0, d[1]}, 64'd0);

    // R11 source port check directed
    wr(3'd2, 32'h1);
    wr(3'd1, 32'hA1);
    rx_pkt(64'h9, 16'h0800, 8'd17, 16'd1234, 16'd319, 4'd1, 4'd1);
    rd(3'd1, d); chk("R11 src mismatch blocks", {63'd0, d[1]}, 64'd0);
    wr(3'd1, 32'h21);
    rx_pkt(64'h9, 16'h0800, 8'd17, 16'd1234, 16'd319, 4'd1, 4'd1);
    rd(3'd1, d); chk("R11 no src check hits R8", {63'd0, d[1]}, 64'd1);
    rd(3'd6, hi);

    // random classifier
    for (int n = 0; n < 400; n++) begin
      logic [2:0] mode; bit sc; logic [3:0] sel;
      logic [15:0] et, sp, dp; logic [7:0] pr; logic [3:0] ver, mt;
      bit exp_hit;
      mode = 3'($urandom_range(0, 7));
      sc = 1'($urandom);
      sel = 4'($urandom_range(0, 3));
      et = ($urandom_range(0, 1) != 0) ? 16'h88F7 : 16'($urandom);
      pr = ($urandom_range(0, 2) != 0) ? 8'd17 : 8'($urandom);
      sp = ($urandom_range(0, 1) != 0) ? 16'd319 : 16'($urandom);
      dp = ($urandom_range(0, 2) != 0) ? 16'd319 : 16'($urandom);
      ver = ($urandom_range(0, 4) != 0) ? 4'($urandom_range(1, 2)) : 4'($urandom);
      mt = ($urandom_range(0, 3) != 0) ? 4'($urandom_range(0, 4)) : 4'($urandom);
      t = {$urandom, $urandom};
      wr(3'd2, {28'd0, sel});
      wr(3'd1, {24'd0, sc, mode, 4'h1});
      rx_pkt(t, et, pr, sp, dp, ver, mt);
      exp_hit = expect_hit(mode, sc, sel, et, pr, sp, dp, ver, mt);
      rd(3'd1, d);
      chk("R7-style classifier R8 R9 R10 R11 R12 valid", {63'd0, d[1]}, {63'd0, exp_hit});
      if (exp_hit) begin
        rx_pkt(~t, 16'h88F7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0);
        rd(3'd5, lo); rd(3'd6, hi);
        chk("R7 rx stamp R4 held", {hi, lo}, t);
        rd(3'd1, d);
        chk("R5 rx cleared", {63'd0, d[1]}, 64'd0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule